// File: doc/BRIEF.md
# Stepper Phase Ring Sequencer

This block generates the four coil-phase lines that a stepping-motor current driver needs. It holds the phase pattern in a four-stage circulating register. Each accepted step request moves the pattern one place along and feeds the bit that falls off the last stage back into the first stage, so every change of pattern is one mechanical step. A run-time mode input picks one of two feedback paths. In the plain path the last stage is returned unchanged. In the twisted path it is returned inverted. Starting from the preset, the plain path repeats every four steps and the twisted path repeats every eight.

The register starts from a pattern with two adjacent ones (Q1..Q4 = 0110). That pattern is loaded on reset and on a synchronous preset command. A synchronous clear drives all phases low. A step-position counter tracks the place within one revolution of a 400-step motor, at 0.9 degrees per step. It raises a one-cycle revolution strobe each time it wraps. A separate one-cycle strobe confirms each step that was taken.

Top module: `stp_stepper_seq`

## Requirements
- R1: While `rst` is high on a clock edge, `phase_q` becomes 4'b0110, `step_pos` becomes 0, and `step_done` and `rev_done` become 0. `phase_q[3]` is Q1 and `phase_q[0]` is Q4.
- R2: On an edge where `rst`, `clr`, `preset` and `step_en` are all low, `phase_q` and `step_pos` keep their values.
- R3: With `twist` low, an accepted step loads Q1 from Q4 and each later stage from the stage before it. From 0110 the sequence is 0011, 1001, 1100, 0110.
- R4: With `twist` high, an accepted step loads Q1 from the inverse of Q4 and shifts the other stages the same way. From 0110 the pattern comes back to 0110 after exactly eight steps and not earlier.
- R5: `clr` high on an edge forces `phase_q` to 0000 and `step_pos` to 0. It takes priority over `preset` and `step_en`, and it raises no `step_done` strobe.
- R6: `preset` high with `clr` low loads `phase_q` with 0110 and `step_pos` with 0. It takes priority over `step_en` and raises no `step_done` strobe.
- R7: `step_done` is high for exactly the one cycle after each edge where a step was accepted (`step_en` high, `clr` and `preset` low). Back-to-back steps give back-to-back strobes.
- R8: `step_pos` increases by one on each accepted step and goes from 399 back to 0.
- R9: `rev_done` is high only in the cycle after the step that wraps `step_pos` from 399 to 0, together with `step_done`.
- R10: Changing `twist` between steps leaves `phase_q` unchanged. The new feedback path applies from the next accepted step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of phases and position |
| preset | input | 1 | Synchronous load of the 0110 start pattern |
| step_en | input | 1 | One step request per cycle it is high |
| twist | input | 1 | 0: plain feedback, 1: inverted feedback |
| phase_q | output | 4 | Coil phases, bit 3 = Q1 through bit 0 = Q4 |
| step_done | output | 1 | One-cycle strobe after each accepted step |
| rev_done | output | 1 | One-cycle strobe when a revolution completes |
| step_pos | output | 9 | Step position within the revolution, 0 to 399 |

## Verification
The hardest condition to reach is the revolution wrap. It needs 400 accepted steps with no intervening clear or preset, and it coincides with a step strobe. The stimulus first issues a preset and then sends an uninterrupted run of more than 400 steps, so the 399-to-0 transition and its strobe fall inside the run. The bench checks the neighbouring positions too. The collision cases are handled the same way: clear, preset and a step request are driven on the same edge in every combination. This shows which command wins and that the losing step neither moves the pattern nor raises a strobe.

// File: rtl/stp_pkg.sv
package stp_pkg;

  typedef enum logic {
    FB_PLAIN = 1'b0,
    FB_TWIST = 1'b1
  } fb_mode_e;

  typedef enum logic [1:0] {
    CMD_HOLD   = 2'd0,
    CMD_STEP   = 2'd1,
    CMD_PRESET = 2'd2,
    CMD_CLEAR  = 2'd3
  } ring_cmd_e;

endpackage

// File: rtl/stp_cmd_arbiter.sv
module stp_cmd_arbiter
  import stp_pkg::*;
(
  input  logic      clr,
  input  logic      preset,
  input  logic      step_en,
  output ring_cmd_e cmd
);

  always_comb begin
    if (clr)          cmd = CMD_CLEAR;
    else if (preset)  cmd = CMD_PRESET;
    else if (step_en) cmd = CMD_STEP;
    else              cmd = CMD_HOLD;
  end

endmodule

// File: rtl/stp_phase_ring.sv
module stp_phase_ring
  import stp_pkg::*;
#(
  parameter int unsigned            STAGES     = 4,
  parameter logic [STAGES-1:0]      PRESET_PAT = 4'b0110
) (
  input  logic              clk,
  input  logic              rst,
  input  ring_cmd_e         cmd,
  input  fb_mode_e          mode,
  output logic [STAGES-1:0] phase
);

  localparam int unsigned FIRST = STAGES - 1;

  logic feedback;
  logic [STAGES-1:0] stage_in;

  always_comb begin
    feedback = (mode == FB_TWIST) ? ~phase[0] : phase[0];
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic stage_q;

    if (k == FIRST) begin : g_head
      assign stage_in[k] = feedback;
    end else begin : g_body
      assign stage_in[k] = phase[k+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= PRESET_PAT[k];
      end else begin
        case (cmd)
          CMD_CLEAR:  stage_q <= 1'b0;
          CMD_PRESET: stage_q <= PRESET_PAT[k];
          CMD_STEP:   stage_q <= stage_in[k];
          default:    stage_q <= stage_q;
        endcase
      end
    end

    assign phase[k] = stage_q;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_HOLD) |=> $stable(phase));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLEAR) |=> (phase == '0));

  p_preset_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRESET) |=> (phase == PRESET_PAT));

  p_plain_weight_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP && mode == FB_PLAIN) |=>
      ($countones(phase) == $countones($past(phase))));

  p_twist_tail_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP && mode == FB_TWIST) |=>
      (phase[FIRST] == ~$past(phase[0])));

endmodule

// File: rtl/stp_rev_counter.sv
module stp_rev_counter
  import stp_pkg::*;
#(
  parameter int unsigned STEPS_PER_REV = 400,
  parameter int unsigned CNT_W         = $clog2(STEPS_PER_REV)
) (
  input  logic             clk,
  input  logic             rst,
  input  ring_cmd_e        cmd,
  output logic [CNT_W-1:0] pos,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS_PER_REV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      case (cmd)
        CMD_CLEAR, CMD_PRESET: pos <= '0;
        CMD_STEP: begin
          if (pos == LAST) begin
            pos  <= '0;
            wrap <= 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: pos <= pos;
      endcase
    end
  end

  p_pos_range_r8: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST);

  p_wrap_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (pos == '0));

  p_pos_advance_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP && pos != LAST) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/stp_stepper_seq.sv
module stp_stepper_seq
  import stp_pkg::*;
#(
  parameter int unsigned       STAGES        = 4,
  parameter logic [STAGES-1:0] PRESET_PAT    = 4'b0110,
  parameter int unsigned       STEPS_PER_REV = 400,
  parameter int unsigned       POS_W         = $clog2(STEPS_PER_REV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              preset,
  input  logic              step_en,
  input  logic              twist,
  output logic [STAGES-1:0] phase_q,
  output logic              step_done,
  output logic              rev_done,
  output logic [POS_W-1:0]  step_pos
);

  ring_cmd_e cmd;
  fb_mode_e  mode;

  assign mode = fb_mode_e'(twist);

  stp_cmd_arbiter u_arb (
    .clr     (clr),
    .preset  (preset),
    .step_en (step_en),
    .cmd     (cmd)
  );

  stp_phase_ring #(
    .STAGES     (STAGES),
    .PRESET_PAT (PRESET_PAT)
  ) u_ring (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .mode  (mode),
    .phase (phase_q)
  );

  stp_rev_counter #(
    .STEPS_PER_REV (STEPS_PER_REV),
    .CNT_W         (POS_W)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .cmd  (cmd),
    .pos  (step_pos),
    .wrap (rev_done)
  );

  always_ff @(posedge clk) begin
    if (rst) step_done <= 1'b0;
    else     step_done <= (cmd == CMD_STEP);
  end

  p_rev_with_step_r9: assert property (@(posedge clk) disable iff (rst)
    rev_done |-> step_done);

  p_done_tracks_step_r7: assert property (@(posedge clk) disable iff (rst)
    (step_en && !clr && !preset) |=> step_done);

  p_no_done_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    (clr || preset) |=> !step_done);

  p_done_moves_pos_r8: assert property (@(posedge clk) disable iff (rst)
    step_done |-> (step_pos != $past(step_pos)));

endmodule

// File: tb/stp_stepper_seq_bench.sv
module stp_stepper_seq_bench;

  logic       clk = 1'b0;
  logic       rst, clr, preset, step_en, twist;
  logic [3:0] phase_q;
  logic       step_done, rev_done;
  logic [8:0] step_pos;

  always #4 clk = ~clk;

  stp_stepper_seq u_stp_stepper_seq (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .preset    (preset),
    .step_en   (step_en),
    .twist     (twist),
    .phase_q   (phase_q),
    .step_done (step_done),
    .rev_done  (rev_done),
    .step_pos  (step_pos)
  );

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit armed  = 0;
  bit done   = 0;

  // behavioural reference: coil states Q1..Q4, position, strobes
  int q[1:4];
  int m_pos;
  int m_sd, m_rd;

  function automatic logic [3:0] m_phase();
    return {q[1][0], q[2][0], q[3][0], q[4][0]};
  endfunction

  always @(posedge clk) begin
    int fb;
    armed = 1;
    cycles++;
    if (rst) begin
      q[1] = 0; q[2] = 1; q[3] = 1; q[4] = 0;
      m_pos = 0; m_sd = 0; m_rd = 0;
    end else begin
      m_sd = 0; m_rd = 0;
      if (clr) begin
        for (int i = 1; i <= 4; i++) q[i] = 0;
        m_pos = 0;
      end else if (preset) begin
        q[1] = 0; q[2] = 1; q[3] = 1; q[4] = 0;
        m_pos = 0;
      end else if (step_en) begin
        fb = twist ? 1 - q[4] : q[4];
        for (int i = 4; i >= 2; i--) q[i] = q[i-1];
        q[1] = fb;
        m_sd = 1;
        if (m_pos == 399) begin m_pos = 0; m_rd = 1; end
        else m_pos = m_pos + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      n_vec++;
      if (phase_q !== m_phase()) begin
        n_fail++;
        $display("FAIL R3 R4 R5 R6 phase_q actual %b expected %b", phase_q, m_phase());
      end
      if (step_pos !== 9'(m_pos)) begin
        n_fail++;
        $display("FAIL R8 step_pos actual %0d expected %0d", step_pos, m_pos);
      end
      if (step_done !== 1'(m_sd)) begin
        n_fail++;
        $display("FAIL R7 step_done actual %b expected %0d", step_done, m_sd);
      end
      if (rev_done !== 1'(m_rd)) begin
        n_fail++;
        $display("FAIL R9 rev_done actual %b expected %0d", rev_done, m_rd);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) begin
      step_en = 1'b1;
      cyc();
    end
    step_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; preset = 1'b0; step_en = 1'b0; twist = 1'b0;
    cyc(); cyc();
    // R1 reset state
    chk("R1 phase", 16'(phase_q), 16'h6);
    chk("R1 pos", 16'(step_pos), 16'd0);
    chk("R1 strobes", 16'({step_done, rev_done}), 16'd0);
    rst = 1'b0;
    cyc(); cyc(); cyc();
    // R2 hold
    chk("R2 hold", 16'(phase_q), 16'h6);

    // R3 plain sequence
    steps(1); chk("R3 step1", 16'(phase_q), 16'h3);
    chk("R7 strobe", 16'(step_done), 16'd1);
    cyc();    chk("R7 single", 16'(step_done), 16'd0);
    steps(1); chk("R3 step2", 16'(phase_q), 16'h9);
    steps(1); chk("R3 step3", 16'(phase_q), 16'hC);
    steps(1); chk("R3 step4", 16'(phase_q), 16'h6);

    // R4 twisted: period eight, no early return
    twist = 1'b1;
    cyc();
    chk("R10 mode change holds", 16'(phase_q), 16'h6);
    for (int i = 1; i <= 7; i++) begin
      steps(1);
      n_vec++;
      if (phase_q === 4'h6) begin
        n_fail++;
        $display("FAIL R4 early repeat at step %0d actual %b expected not 0110", i, phase_q);
      end
    end
    steps(1); chk("R4 period8", 16'(phase_q), 16'h6);
    steps(1); chk("R4 first", 16'(phase_q), 16'hB);

    // R10 switch back to plain mid-sequence: 1011 -> Q4=1 -> 1101
    twist = 1'b0;
    cyc(); chk("R10 held", 16'(phase_q), 16'hB);
    steps(1); chk("R10 plain after switch", 16'(phase_q), 16'hD);

    // R5 clear beats preset and step
    clr = 1'b1; preset = 1'b1; step_en = 1'b1;
    cyc();
    clr = 1'b0; preset = 1'b0; step_en = 1'b0;
    chk("R5 clear", 16'(phase_q), 16'h0);
    chk("R5 no strobe", 16'(step_done), 16'd0);
    chk("R5 pos", 16'(step_pos), 16'd0);
    steps(3); chk("R3 zero stays zero", 16'(phase_q), 16'h0);

    // R6 preset beats step
    preset = 1'b1; step_en = 1'b1;
    cyc();
    preset = 1'b0; step_en = 1'b0;
    chk("R6 preset", 16'(phase_q), 16'h6);
    chk("R6 no strobe", 16'(step_done), 16'd0);
    chk("R6 pos", 16'(step_pos), 16'd0);

    // R8 R9 revolution wrap in one uninterrupted run
    steps(399);
    chk("R8 pos399", 16'(step_pos), 16'd399);
    chk("R9 no early wrap", 16'(rev_done), 16'd0);
    steps(1);
    chk("R8 wrap to zero", 16'(step_pos), 16'd0);
    chk("R9 rev strobe", 16'(rev_done), 16'd1);
    steps(1);
    chk("R9 strobe cleared", 16'(rev_done), 16'd0);
    chk("R8 pos1", 16'(step_pos), 16'd1);

    twist = 1'b1;
    steps(20);
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R1 reset again", 16'(phase_q), 16'h6);
    cyc();
    finish_run();
  end

endmodule